// File: doc/BRIEF.md
# Control Event Interrupt Aggregator

This block gathers thirteen control-path events of a PCIe controller (configuration enable changes, link state, power management handshakes and error reports) onto one main interrupt line. Three of the events come from level signals and fire whenever the level moves, in either direction. The other ten arrive as one-cycle pulses from the controller core.

Every event lands in two 16-bit status registers. The raw register captures the event whatever its enable says. The masked register captures it only if its enable bit is already 1 in the cycle the event is captured. Software changes enables only through a pair of addresses: one sets the bits written as 1 and the other clears them. It clears status bits by writing 1s to them. A small word-addressed port with a combinational read path reaches all four addresses.

Top module: `ctl_event_irq`

## Requirements
- R1: After a synchronous active-low reset, the raw status, masked status and enable registers all read zero and `irq` is low.
- R2: Each event has a fixed bit position. `lvl_cfg[2]` (memory-space enable) maps to bit 14, `lvl_cfg[1]` (bus-master enable) to bit 13 and `lvl_cfg[0]` (link up) to bit 12. `pulse_evt[9:6]` (link reset request, PME received, turn-off acknowledge, turn-off) map to bits 11:8, and `pulse_evt[5:0]` (ECRC error, AXI tag lookup fatal, correctable, non-fatal, fatal, system) map to bits 5:0.
- R3: An event sets its raw status bit (address 0) at the next clock edge, whatever the state of its enable bit.
- R4: An event sets its masked status bit (address 1) only if its enable bit is 1 in the cycle the event is captured.
- R5: A write to address 2 sets the enable bits written as 1. A write to address 3 clears the enable bits written as 1. Bits written as 0 are left unchanged. A read of address 2 or address 3 returns the current enable vector.
- R6: A write to address 0 or address 1 clears the status bits written as 1 and leaves bits written as 0 unchanged. If an event arrives in the same cycle as the clear of its bit, the bit stays set.
- R7: A level input produces one event for each rising transition and one for each falling transition. A steady level produces no event. No event fires in the first cycle after reset, whatever the level.
- R8: `irq` is high exactly while (masked status AND enable) is nonzero. Clearing an enable drops `irq` without clearing the masked status bit.
- R9: Bits 15, 7 and 6 hold no event. They read as zero in every register, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lvl_cfg | input | 3 | Level inputs whose changes are events: [2] memory-space enable, [1] bus-master enable, [0] link up |
| pulse_evt | input | 10 | Single-cycle event pulses, mapped as in R2 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 raw, 1 masked, 2 enable set, 3 enable clear |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| irq | output | 1 | Main interrupt line |

## Verification
The bench drives an event in the same cycle as a write-1 clear of the same bit. A design in which the clear wins would lose that event. It raises events while their enables are off, then turns the enables on. A design that masks at read time instead of at capture would then show those old events as pending in the masked register. It holds the level inputs high through reset and toggles them both ways, which catches a startup false event and a detector that sees only one edge direction. It writes all-ones, including the reserved bits, and clears an enable under a pending event, so that stray bits in the reserved positions or an interrupt tied to the status alone show up at `reg_rdata` and `irq`.

// File: rtl/cei_pkg.sv
// Package for the control event interrupt aggregator.
// Holds the register address encoding, the valid-bit mask and the
// placement of pulse and level events in the 16-bit register word.
package cei_pkg;
    localparam int DATA_W    = 16;
    localparam int NUM_LVL   = 3;
    localparam int NUM_PULSE = 10;
    localparam int ADDR_W    = 2;
    localparam int LVL_BASE  = 12;   // level events occupy bits 14:12
    localparam int PULSE_LO  = 6;    // pulses below this index map 1:1
    localparam int PULSE_GAP = 2;    // reserved bits 7:6 are skipped

    // Bits that hold an event; all others are reserved
    localparam logic [DATA_W-1:0] EVT_MASK = 16'h7F3F;

    typedef enum logic [ADDR_W-1:0] {
        A_RAW   = 2'd0,
        A_MSK   = 2'd1,
        A_ENSET = 2'd2,
        A_ENCLR = 2'd3
    } reg_addr_e;

    // Register bit position of pulse input number idx
    function automatic int pulse_pos(input int idx);
        return (idx < PULSE_LO) ? idx : idx + PULSE_GAP;
    endfunction
endpackage

// File: rtl/cei_level_change.sv
// Level change detector.
// Gives a one-cycle change flag for each level input on both rising and
// falling transitions. Assumes the inputs are already in the clk domain.
// The first cycle after reset only samples and never flags.
module cei_level_change #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] chg
);
    logic         armed_q;
    logic [N-1:0] prev_q;

    // Arm the detector one cycle after reset
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Keep the previous level of this input
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= lvl[i];
        end
        // Flag a change only once the previous level is valid
        assign chg[i] = armed_q & (lvl[i] ^ prev_q[i]);
    end

    // R7
    change_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|chg) |-> (lvl != $past(lvl)));
endmodule

// File: rtl/cei_event_map.sv
// Event placement.
// Places level-change flags and event pulses at their fixed bit
// positions in the register word. Reserved positions stay zero.
module cei_event_map
    import cei_pkg::*;
#(
    parameter int N_LVL   = NUM_LVL,
    parameter int N_PULSE = NUM_PULSE,
    parameter int W       = DATA_W
) (
    input  logic [N_LVL-1:0]   chg,
    input  logic [N_PULSE-1:0] pulse,
    output logic [W-1:0]       evt
);
    // Scatter every input bit into its register position
    always_comb begin
        evt = '0;
        for (int i = 0; i < N_PULSE; i++) evt[pulse_pos(i)] = pulse[i];
        for (int j = 0; j < N_LVL; j++)   evt[LVL_BASE + j] = chg[j];
    end
endmodule

// File: rtl/cei_w1c_status.sv
// Write-1-to-clear status register.
// A bit is set by set_vec and cleared by writing 1 with clr_we. When a
// set and a clear meet in the same cycle, the set wins. Bits outside
// MASK are held at zero.
module cei_w1c_status #(
    parameter int          W    = 16,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] q
);
    logic [W-1:0] clr_bits;

    // Select the bits cleared in this cycle
    assign clr_bits = clr_we ? clr_data : '0;

    // Update status: clear first, then set, so that the set wins
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= ((q & ~clr_bits) | set_vec) & MASK;
    end

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_vec & MASK)) |=> ((q & $past(set_vec & MASK)) == $past(set_vec & MASK)));
    // R9
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q & ~MASK) == '0);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (q == '0));
endmodule

// File: rtl/cei_enable_bank.sv
// Enable register with separate set and clear strobes.
// Assumes set_we and clr_we are never high together (they come from
// different addresses). Bits outside MASK are held at zero.
module cei_enable_bank #(
    parameter int          W    = 16,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Apply a set or a clear mask to the enable vector
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (set_we) q <= (q | wdata) & MASK;
        else if (clr_we) q <= q & ~wdata;
    end

    // R5
    set_only_adds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && !clr_we) |=> ((q & $past(q)) == $past(q)));
    // R5
    clr_only_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((q & ~$past(q)) == '0));
endmodule

// File: rtl/ctl_event_irq.sv
// Control event interrupt aggregator (top).
// Captures events into raw and enable-gated status registers, keeps the
// enable vector behind set and clear addresses, and drives one interrupt
// line from the enabled pending status. The read path is combinational.
module ctl_event_irq
    import cei_pkg::*;
#(
    parameter int N_LVL   = NUM_LVL,
    parameter int N_PULSE = NUM_PULSE,
    parameter int W       = DATA_W,
    parameter int AW      = ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LVL-1:0]   lvl_cfg,
    input  logic [N_PULSE-1:0] pulse_evt,
    input  logic               reg_we,
    input  logic [AW-1:0]      reg_addr,
    input  logic [W-1:0]       reg_wdata,
    output logic [W-1:0]       reg_rdata,
    output logic               irq
);
    logic [N_LVL-1:0] lvl_chg;
    logic [W-1:0]     evt_vec;
    logic [W-1:0]     raw_q, msk_q, en_q;
    logic             wr_raw, wr_msk, wr_enset, wr_enclr;

    // Decode the write strobes per address
    always_comb begin
        wr_raw   = reg_we && (reg_addr == A_RAW);
        wr_msk   = reg_we && (reg_addr == A_MSK);
        wr_enset = reg_we && (reg_addr == A_ENSET);
        wr_enclr = reg_we && (reg_addr == A_ENCLR);
    end

    cei_level_change #(.N(N_LVL)) u_chg (
        .clk(clk), .rst_n(rst_n), .lvl(lvl_cfg), .chg(lvl_chg)
    );

    cei_event_map #(.N_LVL(N_LVL), .N_PULSE(N_PULSE), .W(W)) u_map (
        .chg(lvl_chg), .pulse(pulse_evt), .evt(evt_vec)
    );

    cei_w1c_status #(.W(W), .MASK(EVT_MASK)) u_raw (
        .clk(clk), .rst_n(rst_n), .set_vec(evt_vec),
        .clr_we(wr_raw), .clr_data(reg_wdata), .q(raw_q)
    );

    cei_w1c_status #(.W(W), .MASK(EVT_MASK)) u_msk (
        .clk(clk), .rst_n(rst_n), .set_vec(evt_vec & en_q),
        .clr_we(wr_msk), .clr_data(reg_wdata), .q(msk_q)
    );

    cei_enable_bank #(.W(W), .MASK(EVT_MASK)) u_en (
        .clk(clk), .rst_n(rst_n), .set_we(wr_enset), .clr_we(wr_enclr),
        .wdata(reg_wdata), .q(en_q)
    );

    // Return the register selected by the address
    always_comb begin
        case (reg_addr)
            A_RAW:   reg_rdata = raw_q;
            A_MSK:   reg_rdata = msk_q;
            default: reg_rdata = en_q;
        endcase
    end

    // Raise the line while any enabled bit is pending
    assign irq = |(msk_q & en_q);

    // R4
    msk_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_q & ~$past(msk_q) & ~$past(en_q)) == '0);
    // R3
    raw_follows_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_vec) |=> ((raw_q & $past(evt_vec)) == $past(evt_vec)));
    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);
endmodule

// File: tb/ctl_event_irq_bench.sv
// Self-checking bench: directed corner cases, then seeded random traffic
// compared against a reference model built from the requirements.
module ctl_event_irq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  lvl_cfg = 3'b000;
    logic [9:0]  pulse_evt = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int total = 0, bad = 0;
    bit done = 0;

    // reference model state
    logic [15:0] raw_m = '0, msk_m = '0, en_m = '0;
    logic [2:0]  prev_m = '0;
    bit          armed_m = 0;
    localparam logic [15:0] VM = 16'h7F3F;

    ctl_event_irq u_ctl_event_irq (.*);

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_read(input logic [1:0] a);
        case (a)
            2'd0: return raw_m;
            2'd1: return msk_m;
            default: return en_m;
        endcase
    endfunction

    // Read one address without a clock edge
    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        reg_we = 1'b0; pulse_evt = '0; reg_addr = a;
        #1 v = reg_rdata;
    endtask

    // One clock cycle of stimulus, with model update (starts and ends at negedge)
    task automatic cycle(input logic [2:0] l, input logic [9:0] p, input logic we,
                         input logic [1:0] a, input logic [15:0] d);
        logic [2:0]  chg;
        logic [15:0] evt, clr_r, clr_k;
        lvl_cfg = l; pulse_evt = p; reg_we = we; reg_addr = a; reg_wdata = d;
        #1;
        chk("R5 R6 read path", reg_rdata, model_read(a));
        chk("R8 irq", {15'd0, irq}, {15'd0, |(msk_m & en_m)});
        @(posedge clk);
        chg   = armed_m ? (l ^ prev_m) : 3'b000;
        evt   = {1'b0, chg, p[9:6], 2'b00, p[5:0]};
        clr_r = (we && a == 2'd0) ? d : 16'h0;
        clr_k = (we && a == 2'd1) ? d : 16'h0;
        raw_m = ((raw_m & ~clr_r) | evt) & VM;
        msk_m = ((msk_m & ~clr_k) | (evt & en_m)) & VM;
        if (we && a == 2'd2) en_m = (en_m | d) & VM;
        if (we && a == 2'd3) en_m = en_m & ~d;
        prev_m = l; armed_m = 1;
        @(negedge clk);
        pulse_evt = '0; reg_we = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] v;
        logic [2:0]  l;
        lvl_cfg = 3'b101;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, v); chk("R1 raw reset", v, 16'h0);
        rd(2'd1, v); chk("R1 masked reset", v, 16'h0);
        rd(2'd2, v); chk("R1 enable reset", v, 16'h0);
        chk("R1 irq reset", {15'd0, irq}, 16'h0);
        // R7 no startup event with levels held high
        cycle(3'b101, '0, 0, 2'd0, '0);
        rd(2'd0, v); chk("R7 startup quiet", v, 16'h0);
        // R3 R7 falling link-up edge, enable off
        cycle(3'b100, '0, 0, 2'd0, '0);
        rd(2'd0, v); chk("R3 raw falling edge bit12", v, 16'h1000);
        rd(2'd1, v); chk("R4 masked stays clear when disabled", v, 16'h0);
        // R4 enabling afterwards must not expose the old event
        cycle(3'b100, '0, 1, 2'd2, 16'hFFFF);
        rd(2'd1, v); chk("R4 no late mask", v, 16'h0);
        chk("R4 irq after late enable", {15'd0, irq}, 16'h0);
        // R5 R9 enable readback on both addresses
        rd(2'd2, v); chk("R9 enable reserved bits", v, 16'h7F3F);
        rd(2'd3, v); chk("R5 enable read at clear address", v, 16'h7F3F);
        // R2 R8 turn-off pulse -> bit 8
        cycle(3'b100, 10'b00_0100_0000, 0, 2'd0, '0);
        rd(2'd1, v); chk("R2 pulse6 to bit8", v, 16'h0100);
        chk("R8 irq raised", {15'd0, irq}, 16'h1);
        // R8 dropping the enable lowers irq, status kept
        cycle(3'b100, '0, 1, 2'd3, 16'h0100);
        chk("R8 irq dropped", {15'd0, irq}, 16'h0);
        rd(2'd1, v); chk("R8 masked kept", v, 16'h0100);
        // R6 write zero is no-op, write one clears
        cycle(3'b100, '0, 1, 2'd1, 16'h0000);
        rd(2'd1, v); chk("R6 zero write keeps", v, 16'h0100);
        cycle(3'b100, '0, 1, 2'd1, 16'h0100);
        rd(2'd1, v); chk("R6 one write clears", v, 16'h0000);
        // R6 set wins against a simultaneous clear (system error, bit 0)
        cycle(3'b100, '0, 1, 2'd0, 16'hFFFF);
        cycle(3'b100, 10'b00_0000_0001, 1, 2'd0, 16'h0001);
        rd(2'd0, v); chk("R6 set wins", v, 16'h0001);
        // R7 both edges of memory-space enable
        cycle(3'b100, '0, 1, 2'd0, 16'hFFFF);
        cycle(3'b000, '0, 0, 2'd0, '0);
        rd(2'd0, v); chk("R7 falling bit14", v, 16'h4000);
        cycle(3'b000, '0, 1, 2'd0, 16'hFFFF);
        cycle(3'b000, '0, 0, 2'd0, '0);
        rd(2'd0, v); chk("R7 steady no event", v, 16'h0000);
        cycle(3'b100, '0, 0, 2'd0, '0);
        rd(2'd0, v); chk("R7 rising bit14", v, 16'h4000);
        // R9 reserved writes ignored
        cycle(3'b100, '0, 1, 2'd3, 16'hFFFF);
        cycle(3'b100, '0, 1, 2'd2, 16'h80C0);
        rd(2'd2, v); chk("R9 reserved enable write", v, 16'h0000);
        // random traffic against the model
        void'($urandom(32'h5EED_0C1A));
        l = 3'b100;
        for (int n = 0; n < 4000; n++) begin
            logic [9:0]  p;
            logic [15:0] d;
            if ($urandom_range(0, 7) == 0) l[$urandom_range(0, 2)] ^= 1'b1;
            p = 10'($urandom) & 10'($urandom) & 10'($urandom);
            d = 16'($urandom);
            cycle(l, p, ($urandom_range(0, 2) == 0), 2'($urandom_range(0, 3)), d);
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule